// File: doc/BRIEF.md
# Cell PHY Management Register and Interrupt Block

This block is the management side of a cell-based line interface. A byte-wide utility bus (address, chip select, read strobe, write strobe, write data, read data) reaches one master control register and one read-only status register. The control fields drive the line-side options straight out as pins: an inverted general-purpose output, a transmit halt that pulls both differential transmit lines low, the cell/byte mode select for the cell bus, the transmit parity-check enable and two receive discard enables.

Four event inputs report a short received cell, an invalid received symbol, a header checksum (HEC) error and a transmit parity error. Each event sets its own sticky status bit. Reading the status register returns those bits and clears them. An active-low interrupt pin is built from the sticky bits. Its enable and a cell-error-only qualifier are both control fields.

Top module: `cphy_mgmt`

## Requirements
- R1: The control register is at address 0x00. A write with chip select and write strobe stores all eight data bits, and a read of 0x00 returns them.
- R2: After reset the control register reads 0x09, which is bit 3 and bit 0 set and all other bits clear. The status register reads 0x00 and `irq_n` is high.
- R3: `user_out_n` always carries the inverse of control bit 7.
- R4: Control bit 1 drives `byte_mode` (0 = cell mode, 1 = byte mode). Bit 4 drives `tx_parity_chk_en`, bit 6 drives `rx_drop_err_cells` and bit 3 drives `rx_drop_idle_cells`.
- R5: While control bit 2 is set, `tx_line_p` and `tx_line_n` are both 0. Otherwise they follow `tx_line_p_i` and `tx_line_n_i`.
- R6: The status register is at address 0x01 and is read-only. Its sticky bits are: bit 0 short cell, bit 1 invalid symbol, bit 2 HEC error, bit 3 transmit parity error. An event pulse sets its bit from the next cycle on. Bits 7..4 read 0. A write to 0x01 has no effect.
- R7: `ev_tx_parity` is recorded only while control bit 4 is set.
- R8: A status read returns the bits held before the read and clears them. An event that arrives in the same cycle as the clearing read stays set afterwards.
- R9: While control bit 0 is clear, `irq_n` is high.
- R10: With control bit 0 set and bit 5 clear, `irq_n` is low exactly while any sticky status bit is set.
- R11: With control bits 0 and 5 both set, only status bits 2..0 (the received-cell errors) can pull `irq_n` low.
- R12: A read of any other address returns 0x00. A write to any other address changes no register.
- R13: `bus_rdata` is registered. It shows the read value in the cycle after the read strobe and 0x00 in a cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Utility bus address |
| bus_cs | input | 1 | Chip select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ev_short_cell | input | 1 | Short received cell event |
| ev_bad_symbol | input | 1 | Invalid received symbol event |
| ev_hec_err | input | 1 | Header checksum error event |
| ev_tx_parity | input | 1 | Transmit parity mismatch event |
| tx_line_p_i | input | 1 | Transmit line, positive, from the encoder |
| tx_line_n_i | input | 1 | Transmit line, negative, from the encoder |
| tx_line_p | output | 1 | Gated transmit line, positive |
| tx_line_n | output | 1 | Gated transmit line, negative |
| user_out_n | output | 1 | Inverted general-purpose output |
| byte_mode | output | 1 | Cell bus mode (0 cell, 1 byte) |
| tx_parity_chk_en | output | 1 | Transmit parity check enable |
| rx_drop_err_cells | output | 1 | Discard received error cells |
| rx_drop_idle_cells | output | 1 | Discard received idle cells |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The bench goes after an event that lands in the same cycle as a status read. A design that clears after setting would lose that event, so the next status read would come back zero. It also checks the cell-error-only qualifier with a transmit parity bit pending. A design that ignores bit 5 would drive `irq_n` low there. The non-zero reset value is checked on the first read: a design that resets to zero would read 0x00 and leave the interrupt disabled. Reads and writes to an unmapped address are checked against the control and status contents afterwards, which would expose a decoder that aliases onto 0x00 or 0x01.

// File: rtl/cphy_mgmt_pkg.sv
package cphy_mgmt_pkg;

   localparam int REG_W = 8;

   // control fields, MSB first, so the bit positions follow the field order
   typedef struct packed {
      logic uplo;          // 7
      logic drop_err;      // 6
      logic cellerr_only;  // 5
      logic par_en;        // 4
      logic drop_idle;     // 3
      logic halt;          // 2
      logic byte_mode;     // 1
      logic irq_en;        // 0
   } ctl_t;

   localparam logic [REG_W-1:0] CTL_RESET = 8'h09;

   localparam int EVT_SHORT  = 0;
   localparam int EVT_BADSYM = 1;
   localparam int EVT_HEC    = 2;
   localparam int EVT_TXPAR  = 3;
   localparam int NUM_EVT    = 4;

   localparam logic [NUM_EVT-1:0] CELL_ERR_MASK = 4'b0111;

endpackage

// File: rtl/cphy_ctl_reg.sv
module cphy_ctl_reg #(
   parameter int               W         = 8,
   parameter logic [W-1:0]     RESET_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RESET_VAL;
      else if (we) q <= wdata;
   end

   p_write_lands_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (q == $past(wdata)));

   p_hold_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));

endmodule

// File: rtl/cphy_sticky_bank.sv
module cphy_sticky_bank #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev,
   input  logic         clr,
   output logic [N-1:0] sts
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   bit_q <= 1'b0;
            else if (ev[i]) bit_q <= 1'b1;   // a set wins over a clear in the same cycle
            else if (clr) bit_q <= 1'b0;
         end
         assign sts[i] = bit_q;

         p_event_sets_r6 : assert property (@(posedge clk) disable iff (!rst_n)
            ev[i] |=> sts[i]);

         p_read_clears_r8 : assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !ev[i]) |=> !sts[i]);

         p_sticky_holds_r8 : assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && sts[i]) |=> sts[i]);
      end
   endgenerate

endmodule

// File: rtl/cphy_irq_gen.sv
module cphy_irq_gen #(
   parameter int             N          = 4,
   parameter logic [N-1:0]   CELL_MASK  = '1,
   parameter bit             REGISTERED = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         cell_only,
   input  logic [N-1:0] sts,
   output logic         irq_n
);

   logic [N-1:0] qual;
   logic         req;

   always_comb begin
      qual = cell_only ? (sts & CELL_MASK) : sts;
      req  = en && (|qual);
   end

   generate
      if (REGISTERED) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b1;
            else        irq_q <= !req;
         end
         assign irq_n = irq_q;

         p_mask_reg_r9 : assert property (@(posedge clk) disable iff (!rst_n)
            !en |=> irq_n);
      end else begin : g_comb
         assign irq_n = !req;

         p_mask_r9 : assert property (@(posedge clk) disable iff (!rst_n)
            !en |-> irq_n);

         p_any_r10 : assert property (@(posedge clk) disable iff (!rst_n)
            (en && !cell_only && (sts != '0)) |-> !irq_n);

         p_cell_only_r11 : assert property (@(posedge clk) disable iff (!rst_n)
            (en && cell_only && ((sts & CELL_MASK) == '0)) |-> irq_n);
      end
   endgenerate

endmodule

// File: rtl/cphy_mgmt.sv
module cphy_mgmt
   import cphy_mgmt_pkg::*;
#(
   parameter int  ADDR_W       = 8,
   parameter int  DATA_W       = 8,
   parameter int  CTL_ADDR     = 0,
   parameter int  STS_ADDR     = 1,
   parameter bit  IRQ_REGISTER = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_cs,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ev_short_cell,
   input  logic              ev_bad_symbol,
   input  logic              ev_hec_err,
   input  logic              ev_tx_parity,
   input  logic              tx_line_p_i,
   input  logic              tx_line_n_i,
   output logic              tx_line_p,
   output logic              tx_line_n,
   output logic              user_out_n,
   output logic              byte_mode,
   output logic              tx_parity_chk_en,
   output logic              rx_drop_err_cells,
   output logic              rx_drop_idle_cells,
   output logic              irq_n
);

   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_ADDR);
   localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(STS_ADDR);
   localparam int                PAD_W = DATA_W - NUM_EVT;

   generate
      if (DATA_W != REG_W) begin : g_bad_width
         $error("cphy_mgmt: DATA_W must equal the register width");
      end
      if (CTL_ADDR == STS_ADDR) begin : g_bad_map
         $error("cphy_mgmt: register addresses overlap");
      end
      if (CTL_ADDR >= (1 << ADDR_W) || STS_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("cphy_mgmt: register address out of range");
      end
   endgenerate

   // decode
   logic hit_ctl, hit_sts, rd_acc, wr_acc;
   always_comb begin
      hit_ctl = (bus_addr == A_CTL);
      hit_sts = (bus_addr == A_STS);
      rd_acc  = bus_cs && bus_rd;
      wr_acc  = bus_cs && bus_wr;
   end

   // control register
   logic [DATA_W-1:0] ctl_raw;
   ctl_t              ctl;

   cphy_ctl_reg #(.W(DATA_W), .RESET_VAL(CTL_RESET)) i_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_acc && hit_ctl),
      .wdata (bus_wdata),
      .q     (ctl_raw)
   );
   assign ctl = ctl_t'(ctl_raw);

   // sticky status
   logic [NUM_EVT-1:0] ev_vec, sts;
   always_comb begin
      ev_vec             = '0;
      ev_vec[EVT_SHORT]  = ev_short_cell;
      ev_vec[EVT_BADSYM] = ev_bad_symbol;
      ev_vec[EVT_HEC]    = ev_hec_err;
      ev_vec[EVT_TXPAR]  = ev_tx_parity && ctl.par_en;
   end

   cphy_sticky_bank #(.N(NUM_EVT)) i_sts (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (ev_vec),
      .clr   (rd_acc && hit_sts),
      .sts   (sts)
   );

   // interrupt
   cphy_irq_gen #(.N(NUM_EVT), .CELL_MASK(CELL_ERR_MASK), .REGISTERED(IRQ_REGISTER)) i_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (ctl.irq_en),
      .cell_only (ctl.cellerr_only),
      .sts       (sts),
      .irq_n     (irq_n)
   );

   // read data
   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (hit_ctl)      rd_mux = ctl_raw;
      else if (hit_sts) rd_mux = {{PAD_W{1'b0}}, sts};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (rd_acc) bus_rdata <= rd_mux;
      else             bus_rdata <= '0;
   end

   // line-side pins
   always_comb begin
      user_out_n         = !ctl.uplo;
      byte_mode          = ctl.byte_mode;
      tx_parity_chk_en   = ctl.par_en;
      rx_drop_err_cells  = ctl.drop_err;
      rx_drop_idle_cells = ctl.drop_idle;
      tx_line_p          = tx_line_p_i && !ctl.halt;
      tx_line_n          = tx_line_n_i && !ctl.halt;
   end

   p_halt_low_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata == bus_rdata) && ctl.halt |-> (!tx_line_p && !tx_line_n));

   p_unmapped_zero_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && !hit_ctl && !hit_sts) |=> (bus_rdata == '0));

   p_idle_bus_r13 : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_acc |=> (bus_rdata == '0));

endmodule

// File: tb/test_cphy_mgmt.sv
module test_cphy_mgmt;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0;
   logic       bus_cs = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       ev_short_cell = 1'b0, ev_bad_symbol = 1'b0, ev_hec_err = 1'b0, ev_tx_parity = 1'b0;
   logic       tx_line_p_i = 1'b0, tx_line_n_i = 1'b1;
   logic       tx_line_p, tx_line_n, user_out_n, byte_mode;
   logic       tx_parity_chk_en, rx_drop_err_cells, rx_drop_idle_cells, irq_n;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;   // 50 MHz

   cphy_mgmt i_cphy_mgmt (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ev_short_cell(ev_short_cell), .ev_bad_symbol(ev_bad_symbol),
      .ev_hec_err(ev_hec_err), .ev_tx_parity(ev_tx_parity),
      .tx_line_p_i(tx_line_p_i), .tx_line_n_i(tx_line_n_i),
      .tx_line_p(tx_line_p), .tx_line_n(tx_line_n),
      .user_out_n(user_out_n), .byte_mode(byte_mode),
      .tx_parity_chk_en(tx_parity_chk_en), .rx_drop_err_cells(rx_drop_err_cells),
      .rx_drop_idle_cells(rx_drop_idle_cells), .irq_n(irq_n)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   logic [7:0] m_ctl, m_sts, m_rd;
   always @(posedge clk) begin
      logic [7:0] oc, os, ev;
      if (!rst_n) begin
         m_ctl = 8'h09; m_sts = 8'h00; m_rd = 8'h00;
      end else begin
         oc = m_ctl; os = m_sts;
         ev = {4'b0, ev_tx_parity & oc[4], ev_hec_err, ev_bad_symbol, ev_short_cell};
         if (bus_cs && bus_rd)
            m_rd = (bus_addr == 8'h00) ? oc : (bus_addr == 8'h01) ? os : 8'h00;
         else
            m_rd = 8'h00;
         if (bus_cs && bus_wr && bus_addr == 8'h00) m_ctl = bus_wdata;
         m_sts = ((bus_cs && bus_rd && bus_addr == 8'h01) ? 8'h00 : os) | ev;
      end
   end

   function automatic logic m_irq_n();
      logic [7:0] q;
      q = m_ctl[5] ? (m_sts & 8'h07) : m_sts;
      return !(m_ctl[0] && (q != 0));
   endfunction

   // compare every cycle, then move the line inputs
   int cyc = 0;
   always @(negedge clk) begin
      if (rst_n && cyc > 2) begin
         chk("R13 rdata",        bus_rdata,                 m_rd);
         chk("R10 irq_n",        {7'b0, irq_n},             {7'b0, m_irq_n()});
         chk("R3 user_out_n",    {7'b0, user_out_n},        {7'b0, ~m_ctl[7]});
         chk("R4 pins",          {4'b0, byte_mode, tx_parity_chk_en, rx_drop_err_cells, rx_drop_idle_cells},
                                 {4'b0, m_ctl[1], m_ctl[4], m_ctl[6], m_ctl[3]});
         chk("R5 lines",         {6'b0, tx_line_p, tx_line_n},
                                 {6'b0, tx_line_p_i & ~m_ctl[2], tx_line_n_i & ~m_ctl[2]});
      end
      cyc++;
      tx_line_p_i = cyc[0];
      tx_line_n_i = ~cyc[1];
   end

   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_cs = 1'b1; bus_wr = 1'b1;
      @(negedge clk);
      bus_cs = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_cs = 1'b1; bus_rd = 1'b1;
      @(negedge clk);
      #1 d = bus_rdata;
      bus_cs = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: ev_short_cell = 1'b1;
         1: ev_bad_symbol = 1'b1;
         2: ev_hec_err    = 1'b1;
         default: ev_tx_parity = 1'b1;
      endcase
      @(negedge clk);
      ev_short_cell = 1'b0; ev_bad_symbol = 1'b0; ev_hec_err = 1'b0; ev_tx_parity = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R2 reset state
      chk("R2 irq_n after reset", {7'b0, irq_n}, 8'h01);
      bus_read(8'h00, d); chk("R2 ctl reset", d, 8'h09);
      bus_read(8'h01, d); chk("R2 sts reset", d, 8'h00);

      // R1 write and read back, R3 inverted output
      bus_write(8'h00, 8'h89);
      #1 chk("R3 user_out_n low", {7'b0, user_out_n}, 8'h00);
      bus_read(8'h00, d); chk("R1 readback", d, 8'h89);

      // R4 field pins
      bus_write(8'h00, 8'h5B);
      #1 chk("R4 byte/par/err/idle", {4'b0, byte_mode, tx_parity_chk_en, rx_drop_err_cells, rx_drop_idle_cells}, 8'h0F);
      bus_write(8'h00, 8'h01);
      #1 chk("R4 all clear", {4'b0, byte_mode, tx_parity_chk_en, rx_drop_err_cells, rx_drop_idle_cells}, 8'h00);

      // R5 halt
      bus_write(8'h00, 8'h0D);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk); #1 chk("R5 halted lines", {6'b0, tx_line_p, tx_line_n}, 8'h00);
      end
      bus_write(8'h00, 8'h09);

      // R6 and R10: short cell sets bit 0 and pulls irq low
      pulse(0);
      #1 chk("R10 irq low on sticky", {7'b0, irq_n}, 8'h00);
      bus_read(8'h01, d); chk("R6 short cell bit", d, 8'h01);
      bus_read(8'h01, d); chk("R8 cleared by read", d, 8'h00);
      #1 chk("R10 irq released", {7'b0, irq_n}, 8'h01);

      // R6 write to status ignored
      pulse(1);
      bus_write(8'h01, 8'h00);
      bus_read(8'h01, d); chk("R6 status write ignored", d, 8'h02);

      // R7 parity event gated by bit 4
      pulse(3);
      bus_read(8'h01, d); chk("R7 parity ignored when off", d, 8'h00);
      bus_write(8'h00, 8'h19);
      pulse(3);
      bus_read(8'h01, d); chk("R7 parity recorded", d, 8'h08);

      // R11 cell-error-only qualifier
      bus_write(8'h00, 8'h39);
      pulse(3);
      #1 chk("R11 parity does not interrupt", {7'b0, irq_n}, 8'h01);
      pulse(2);
      #1 chk("R11 hec interrupts", {7'b0, irq_n}, 8'h00);

      // R9 interrupt disabled
      bus_write(8'h00, 8'h18);
      #1 chk("R9 irq masked", {7'b0, irq_n}, 8'h01);
      bus_read(8'h01, d); chk("R6 hec and parity", d, 8'h0C);

      // R8 event in the same cycle as the clearing read
      bus_write(8'h00, 8'h09);
      pulse(0);
      @(negedge clk);
      bus_addr = 8'h01; bus_cs = 1'b1; bus_rd = 1'b1; ev_bad_symbol = 1'b1;
      @(negedge clk);
      #1 d = bus_rdata;
      bus_cs = 1'b0; bus_rd = 1'b0; ev_bad_symbol = 1'b0;
      chk("R8 old value returned", d, 8'h01);
      bus_read(8'h01, d); chk("R8 same-cycle event kept", d, 8'h02);

      // R12 unmapped address
      bus_write(8'h05, 8'hFF);
      bus_write(8'h81, 8'hFF);
      bus_read(8'h05, d); chk("R12 unmapped read", d, 8'h00);
      bus_read(8'h00, d); chk("R12 ctl untouched", d, 8'h09);
      pulse(2);
      bus_read(8'h02, d); chk("R12 unmapped read with sticky", d, 8'h00);
      bus_read(8'h01, d); chk("R12 sts untouched", d, 8'h04);

      // R13 idle bus returns zero
      repeat (2) @(negedge clk);
      #1 chk("R13 idle rdata", bus_rdata, 8'h00);

      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule